// File: doc/BRIEF.md
# Serial Buffer with Watermark Interrupts

This block sits between a UART character deserializer/serializer and a host. Bytes arriving from the line are stored in a receive queue that the host empties. Bytes from the host are stored in a transmit queue that the line side empties through a ready/valid handshake. Both queues are 128 entries deep. Their occupancy is visible on two 8-bit count outputs.

The host gets a single interrupt line. It is built from five causes:

- the receive queue reaching a programmable high-water level;
- the transmit queue falling under a programmable low-water level;
- receive data going stale, with no new byte for a programmable number of character times;
- a sticky receive overflow, during which every incoming byte is thrown away;
- a host attempt to push into a full transmit queue.

The three programmable levels sit in internal registers. These registers load from the configuration inputs on a strobe. Each level has its own power-up value.

Top module: `sbuf_top`

## Requirements
- R1: Each queue holds up to 128 bytes and returns them in arrival order. `rxCount` and `txCount` give the exact occupancy, and both are 0 after reset.
- R2: A push and a pop in the same cycle on a queue that is neither empty nor full leave its occupancy unchanged and raise no error.
- R3: A host pop of an empty receive queue leaves `rxCount` at 0. While the receive queue is empty, `hostRxData` reads 0.
- R4: Status bit 0 (receive high-water) sets when `rxCount` is greater than or equal to the receive level. That level is 120 after reset.
- R5: Status bit 1 (transmit low-water) sets when `txCount` is strictly less than the transmit level. That level is 10 after reset.
- R6: An idle counter advances on each `baudTick`. It returns to 0 on every accepted received byte and is held at 0 while the receive queue is empty. Status bit 2 (receive stale) sets when three conditions hold together:
  - the counter has reached the stale setting times 10 ticks;
  - the queue is non-empty;
  - the queue is below the receive level.

  The stale setting is 10 character times after reset.
- R7: A received byte that arrives while `rxCount` is 128 sets status bit 3 (overflow). While bit 3 is set, every received byte is discarded, even if room has been made. Bit 3 stays set until the host clears it.
- R8: A host push while `txCount` is 128 is ignored and sets status bit 4 (transmit push error). This holds even if the line side takes a byte in the same cycle.
- R9: A 1 in `irqClear[k]` clears status bit k at the next edge, and the clear takes priority over any set in that cycle. A level cause (bits 0 to 2) whose condition still holds sets its bit again one cycle later.
- R10: `irq` is high exactly when some status bit is set together with the matching `irqEnable` bit.
- R11: A `cfgLoad` strobe loads all three levels from the configuration inputs at the next edge. A field of value 0 is ignored and keeps the previous setting.
- R12: `txByteValid` is high whenever the transmit queue is non-empty, and `txByte` shows its oldest byte. A cycle with `txByteValid` and `txReady` both high removes that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxByteValid | input | 1 | Strobe: a received byte is on `rxByte` |
| rxByte | input | 8 | Byte from the deserializer |
| baudTick | input | 1 | One pulse per line bit period |
| hostRxPop | input | 1 | Host removes the oldest received byte |
| hostRxData | output | 8 | Oldest received byte, 0 when empty |
| hostTxPush | input | 1 | Host writes `hostTxData` into the transmit queue |
| hostTxData | input | 8 | Byte to transmit |
| txReady | input | 1 | Serializer can accept a byte |
| txByteValid | output | 1 | Transmit queue has a byte for the serializer |
| txByte | output | 8 | Oldest transmit byte |
| cfgLoad | input | 1 | Load strobe for the three levels |
| cfgRxHigh | input | 7 | Receive high-water level, 1 to 127 |
| cfgTxLow | input | 7 | Transmit low-water level, 1 to 127 |
| cfgRxIdle | input | 7 | Receive stale time in character times, 1 to 127 |
| irqEnable | input | 5 | Per-cause enable |
| irqClear | input | 5 | Per-cause write-one-to-clear strobe |
| irqStatus | output | 5 | Cause status bits |
| irq | output | 1 | Combined interrupt |
| rxCount | output | 8 | Receive occupancy |
| txCount | output | 8 | Transmit occupancy |

## Verification
The bound assertions check several rules on every cycle:

- occupancy never exceeds the depth;
- overflow stays sticky and occupancy cannot grow while it is set;
- a clear always wins;
- a full transmit push always raises the error bit;
- simultaneous push and pop, and an empty pop, leave the count as it was;
- the valid output tracks transmit occupancy.

Some behaviour only the bench scenarios can show:

- the exact threshold crossings at the default and loaded levels;
- the stale timer expiring on the exact tick;
- data ordering through full wrap-around of both queues;
- level causes returning after a clear;
- configuration writes of zero being ignored.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;
  localparam int NUM_CAUSES = 5;
  localparam int CAUSE_RX_HIGH = 0;
  localparam int CAUSE_TX_LOW = 1;
  localparam int CAUSE_RX_STALE = 2;
  localparam int CAUSE_RX_OVF = 3;
  localparam int CAUSE_TX_ERR = 4;

  localparam int RX_HIGH_DEF = 120;
  localparam int TX_LOW_DEF = 10;
  localparam int RX_IDLE_DEF = 10;

  typedef struct packed {
    logic rxPush;
    logic rxPop;
    logic txPush;
    logic txPop;
  } queueStrobes_t;
endpackage

// File: rtl/sbuf_fifo.sv
module sbuf_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH = 128,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              push,
  input  logic              pop,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [CNT_W-1:0]  count
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= nextPtr(wrPtr);
      if (pop) rdPtr <= nextPtr(rdPtr);
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end

  assign rdData = (count == '0) ? '0 : mem[rdPtr];
endmodule

// File: rtl/sbuf_datapath.sv
module sbuf_datapath import sbuf_pkg::*; #(
  parameter int DATA_W = 8,
  parameter int DEPTH = 128,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  queueStrobes_t     strb,
  input  logic [DATA_W-1:0] rxByte,
  input  logic [DATA_W-1:0] hostTxData,
  output logic [DATA_W-1:0] hostRxData,
  output logic [DATA_W-1:0] txByte,
  output logic [CNT_W-1:0]  rxCount,
  output logic [CNT_W-1:0]  txCount
);
  sbuf_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_rxQ (
    .clk(clk), .rstN(rstN), .push(strb.rxPush), .pop(strb.rxPop),
    .wrData(rxByte), .rdData(hostRxData), .count(rxCount)
  );

  sbuf_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_txQ (
    .clk(clk), .rstN(rstN), .push(strb.txPush), .pop(strb.txPop),
    .wrData(hostTxData), .rdData(txByte), .count(txCount)
  );
endmodule

// File: rtl/sbuf_control.sv
module sbuf_control import sbuf_pkg::*; #(
  parameter int DEPTH = 128,
  parameter int THR_W = 7,
  parameter int CHAR_BITS = 10,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int TMO_W = $clog2(((1 << THR_W) - 1) * CHAR_BITS + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  rxByteValid,
  input  logic                  baudTick,
  input  logic                  hostRxPop,
  input  logic                  hostTxPush,
  input  logic                  txReady,
  input  logic                  cfgLoad,
  input  logic [THR_W-1:0]      cfgRxHigh,
  input  logic [THR_W-1:0]      cfgTxLow,
  input  logic [THR_W-1:0]      cfgRxIdle,
  input  logic [NUM_CAUSES-1:0] irqEnable,
  input  logic [NUM_CAUSES-1:0] irqClear,
  input  logic [CNT_W-1:0]      rxCount,
  input  logic [CNT_W-1:0]      txCount,
  output queueStrobes_t         strb,
  output logic                  txByteValid,
  output logic [NUM_CAUSES-1:0] irqStatus,
  output logic                  irq
);
  logic [THR_W-1:0] rxHighThr, txLowThr, rxIdleThr;
  logic [TMO_W-1:0] idleCnt, idleLimit;
  logic rxFull, rxEmpty, txFull, txEmpty;
  logic rxHighCond, txLowCond, staleCond, ovfEvent, txErrEvent;
  logic [NUM_CAUSES-1:0] setCause;

  // Level registers with their power-up values; zero writes are ignored.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxHighThr <= THR_W'(RX_HIGH_DEF);
      txLowThr  <= THR_W'(TX_LOW_DEF);
      rxIdleThr <= THR_W'(RX_IDLE_DEF);
    end else if (cfgLoad) begin
      if (cfgRxHigh != '0) rxHighThr <= cfgRxHigh;
      if (cfgTxLow != '0) txLowThr <= cfgTxLow;
      if (cfgRxIdle != '0) rxIdleThr <= cfgRxIdle;
    end
  end

  assign rxFull  = (rxCount == CNT_W'(DEPTH));
  assign rxEmpty = (rxCount == '0);
  assign txFull  = (txCount == CNT_W'(DEPTH));
  assign txEmpty = (txCount == '0);

  // Queue strobes handed to the datapath.
  always_comb begin
    strb.rxPush = rxByteValid && !rxFull && !irqStatus[CAUSE_RX_OVF];
    strb.rxPop  = hostRxPop && !rxEmpty;
    strb.txPush = hostTxPush && !txFull;
    strb.txPop  = txReady && !txEmpty;
  end
  assign txByteValid = !txEmpty;

  // Idle timer in baud ticks.
  assign idleLimit = TMO_W'(rxIdleThr) * TMO_W'(CHAR_BITS);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) idleCnt <= '0;
    else if (strb.rxPush || rxEmpty) idleCnt <= '0;
    else if (baudTick && (idleCnt < idleLimit)) idleCnt <= idleCnt + TMO_W'(1);
  end

  assign rxHighCond = (rxCount >= CNT_W'(rxHighThr));
  assign txLowCond  = (txCount < CNT_W'(txLowThr));
  assign staleCond  = !rxEmpty && !rxHighCond && (idleCnt >= idleLimit);
  assign ovfEvent   = rxByteValid && rxFull;
  assign txErrEvent = hostTxPush && txFull;

  always_comb begin
    setCause = '0;
    setCause[CAUSE_RX_HIGH]  = rxHighCond;
    setCause[CAUSE_TX_LOW]   = txLowCond;
    setCause[CAUSE_RX_STALE] = staleCond;
    setCause[CAUSE_RX_OVF]   = ovfEvent;
    setCause[CAUSE_TX_ERR]   = txErrEvent;
  end

  // Status bits: clear takes priority over set.
  for (genvar k = 0; k < NUM_CAUSES; k++) begin : g_cause
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) irqStatus[k] <= 1'b0;
      else if (irqClear[k]) irqStatus[k] <= 1'b0;
      else if (setCause[k]) irqStatus[k] <= 1'b1;
    end
  end

  assign irq = |(irqStatus & irqEnable);
endmodule

// File: rtl/sbuf_top.sv
module sbuf_top import sbuf_pkg::*; #(
  parameter int DATA_W = 8,
  parameter int DEPTH = 128,
  parameter int THR_W = 7,
  parameter int CHAR_BITS = 10,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  rxByteValid,
  input  logic [DATA_W-1:0]     rxByte,
  input  logic                  baudTick,
  input  logic                  hostRxPop,
  output logic [DATA_W-1:0]     hostRxData,
  input  logic                  hostTxPush,
  input  logic [DATA_W-1:0]     hostTxData,
  input  logic                  txReady,
  output logic                  txByteValid,
  output logic [DATA_W-1:0]     txByte,
  input  logic                  cfgLoad,
  input  logic [THR_W-1:0]      cfgRxHigh,
  input  logic [THR_W-1:0]      cfgTxLow,
  input  logic [THR_W-1:0]      cfgRxIdle,
  input  logic [NUM_CAUSES-1:0] irqEnable,
  input  logic [NUM_CAUSES-1:0] irqClear,
  output logic [NUM_CAUSES-1:0] irqStatus,
  output logic                  irq,
  output logic [CNT_W-1:0]      rxCount,
  output logic [CNT_W-1:0]      txCount
);
  queueStrobes_t strb;

  sbuf_control #(.DEPTH(DEPTH), .THR_W(THR_W), .CHAR_BITS(CHAR_BITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .rxByteValid(rxByteValid), .baudTick(baudTick),
    .hostRxPop(hostRxPop), .hostTxPush(hostTxPush), .txReady(txReady),
    .cfgLoad(cfgLoad), .cfgRxHigh(cfgRxHigh), .cfgTxLow(cfgTxLow),
    .cfgRxIdle(cfgRxIdle), .irqEnable(irqEnable), .irqClear(irqClear),
    .rxCount(rxCount), .txCount(txCount), .strb(strb),
    .txByteValid(txByteValid), .irqStatus(irqStatus), .irq(irq)
  );

  sbuf_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .rxByte(rxByte),
    .hostTxData(hostTxData), .hostRxData(hostRxData), .txByte(txByte),
    .rxCount(rxCount), .txCount(txCount)
  );
endmodule

// File: rtl/sbuf_chk.sv
module sbuf_chk #(
  parameter int DEPTH = 128,
  parameter int NC = 5,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             rxByteValid,
  input logic             hostRxPop,
  input logic             hostTxPush,
  input logic             txReady,
  input logic             txByteValid,
  input logic [NC-1:0]    irqClear,
  input logic [NC-1:0]    irqStatus,
  input logic [CNT_W-1:0] rxCount,
  input logic [CNT_W-1:0] txCount
);
  // R1
  count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxCount <= CNT_W'(DEPTH)) && (txCount <= CNT_W'(DEPTH)));

  // R2
  rx_pushpop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxByteValid && hostRxPop && rxCount != '0 && rxCount != CNT_W'(DEPTH) && !irqStatus[3])
      |=> rxCount == $past(rxCount));

  // R3
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostRxPop && rxCount == '0 && !rxByteValid) |=> rxCount == '0);

  // R7
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqStatus[3] && !irqClear[3]) |=> irqStatus[3]);

  // R7
  ovf_discard_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqStatus[3] |=> rxCount <= $past(rxCount));

  // R8
  tx_full_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostTxPush && txCount == CNT_W'(DEPTH) && !irqClear[4]) |=> irqStatus[4]);

  // R9
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqClear[0] |=> !irqStatus[0]);

  // R12
  tx_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    txByteValid == (txCount != '0));
endmodule

bind sbuf_top sbuf_chk #(.DEPTH(DEPTH), .NC(sbuf_pkg::NUM_CAUSES), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .rxByteValid(rxByteValid), .hostRxPop(hostRxPop),
  .hostTxPush(hostTxPush), .txReady(txReady), .txByteValid(txByteValid),
  .irqClear(irqClear), .irqStatus(irqStatus), .rxCount(rxCount), .txCount(txCount)
);

// File: tb/sbuf_top_tb.sv
`timescale 1ns/1ps
module sbuf_top_tb;
  localparam int DEPTH = 128;
  localparam int B_HIGH = 0, B_LOW = 1, B_STALE = 2, B_OVF = 3, B_ERR = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxByteValid = 1'b0, baudTick = 1'b0, hostRxPop = 1'b0;
  logic hostTxPush = 1'b0, txReady = 1'b0, cfgLoad = 1'b0;
  logic [7:0] rxByte = '0, hostTxData = '0;
  logic [6:0] cfgRxHigh = '0, cfgTxLow = '0, cfgRxIdle = '0;
  logic [4:0] irqEnable = '0, irqClear = '0;
  logic [7:0] hostRxData, txByte, rxCount, txCount;
  logic [4:0] irqStatus;
  logic txByteValid, irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [7:0] rxQ[$];
  logic [7:0] txQ[$];
  bit ovfM = 1'b0;
  int seed = 0;

  always #5 clk = ~clk;

  sbuf_top u_dut (
    .clk(clk), .rstN(rstN), .rxByteValid(rxByteValid), .rxByte(rxByte),
    .baudTick(baudTick), .hostRxPop(hostRxPop), .hostRxData(hostRxData),
    .hostTxPush(hostTxPush), .hostTxData(hostTxData), .txReady(txReady),
    .txByteValid(txByteValid), .txByte(txByte), .cfgLoad(cfgLoad),
    .cfgRxHigh(cfgRxHigh), .cfgTxLow(cfgTxLow), .cfgRxIdle(cfgRxIdle),
    .irqEnable(irqEnable), .irqClear(irqClear), .irqStatus(irqStatus),
    .irq(irq), .rxCount(rxCount), .txCount(txCount)
  );

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic chkEq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] nextVal();
    seed = seed + 1;
    return 8'((seed * 37 + 11) & 255);
  endfunction

  task automatic rxSend(input logic [7:0] v);
    if (!ovfM && rxQ.size() < DEPTH) rxQ.push_back(v);
    else ovfM = 1'b1;
    rxByteValid = 1'b1; rxByte = v;
    cyc();
    rxByteValid = 1'b0;
  endtask

  task automatic txSend(input logic [7:0] v);
    if (txQ.size() < DEPTH) txQ.push_back(v);
    hostTxPush = 1'b1; hostTxData = v;
    cyc();
    hostTxPush = 1'b0;
  endtask

  task automatic rxTake(input string tag);
    chkEq(tag, int'(hostRxData), int'(rxQ[0]));
    hostRxPop = 1'b1;
    cyc();
    hostRxPop = 1'b0;
    void'(rxQ.pop_front());
  endtask

  task automatic txTake(input string tag);
    chkEq(tag, int'(txByte), int'(txQ[0]));
    txReady = 1'b1;
    cyc();
    txReady = 1'b0;
    void'(txQ.pop_front());
  endtask

  task automatic clr(input logic [4:0] m);
    irqClear = m;
    if (m[B_OVF]) ovfM = 1'b0;
    cyc();
    irqClear = '0;
  endtask

  task automatic cfgSet(input int h, input int l, input int i);
    cfgLoad = 1'b1;
    cfgRxHigh = 7'(h); cfgTxLow = 7'(l); cfgRxIdle = 7'(i);
    cyc();
    cfgLoad = 1'b0;
  endtask

  task automatic ticks(input int n);
    baudTick = 1'b1;
    repeat (n) cyc();
    baudTick = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // Reset state (R1, R3, R10, R12)
    repeat (3) cyc();
    chkEq("R1 reset rxCount", int'(rxCount), 0);
    chkEq("R1 reset txCount", int'(txCount), 0);
    chkEq("R9 reset status", int'(irqStatus), 0);
    chkEq("R10 reset irq", int'(irq), 0);
    chkEq("R12 reset txByteValid", int'(txByteValid), 0);
    chkEq("R3 reset rx data", int'(hostRxData), 0);
    rstN = 1'b1;
    cyc();

    // R6 default stale time 10 chars = 100 ticks
    rxSend(nextVal());
    ticks(99); cyc();
    chkEq("R6 default stale before", int'(irqStatus[B_STALE]), 0);
    ticks(1); cyc();
    chkEq("R6 default stale at 100", int'(irqStatus[B_STALE]), 1);
    clr(5'b00100);

    // R4 default high level 120
    repeat (118) rxSend(nextVal());
    cyc();
    chkEq("R4 count 119", int'(rxCount), 119);
    chkEq("R4 default below", int'(irqStatus[B_HIGH]), 0);
    rxSend(nextVal()); cyc();
    chkEq("R4 default at 120", int'(irqStatus[B_HIGH]), 1);

    // R7 overflow and discard
    repeat (8) rxSend(nextVal());
    chkEq("R1 full count", int'(rxCount), DEPTH);
    rxSend(nextVal());
    chkEq("R7 overflow set", int'(irqStatus[B_OVF]), 1);
    chkEq("R7 count after overflow", int'(rxCount), DEPTH);
    rxTake("R1 order first");
    rxSend(nextVal());
    chkEq("R7 discard while sticky", int'(rxCount), DEPTH - 1);
    clr(5'b01000);
    chkEq("R7 cleared", int'(irqStatus[B_OVF]), 0);
    rxSend(nextVal());
    chkEq("R7 accepted after clear", int'(rxCount), DEPTH);
    while (rxQ.size() > 0) rxTake("R1 rx order");
    chkEq("R1 drained", int'(rxCount), 0);
    hostRxPop = 1'b1; cyc(); hostRxPop = 1'b0;
    chkEq("R3 empty pop count", int'(rxCount), 0);
    chkEq("R3 empty data", int'(hostRxData), 0);

    // R5 default low level 10
    repeat (10) txSend(nextVal());
    clr(5'b00010); cyc();
    chkEq("R5 default at 10", int'(irqStatus[B_LOW]), 0);
    txTake("R12 tx order"); cyc();
    chkEq("R5 default below 10", int'(irqStatus[B_LOW]), 1);
    while (txQ.size() > 0) txTake("R12 tx order");

    // Loaded levels: high 4, low 3, stale 2
    cfgSet(4, 3, 2);
    rxSend(nextVal()); rxSend(nextVal());
    rxQ.push_back(8'h3C);
    chkEq("R2 data during pushpop", int'(hostRxData), int'(rxQ[0]));
    rxByteValid = 1'b1; rxByte = 8'h3C; hostRxPop = 1'b1;
    cyc();
    rxByteValid = 1'b0; hostRxPop = 1'b0;
    void'(rxQ.pop_front());
    chkEq("R2 rx pushpop count", int'(rxCount), 2);
    while (rxQ.size() > 0) rxTake("R1 rx order small");

    // R6 stale with 20 ticks
    clr(5'b11111);
    ticks(50); cyc();
    chkEq("R6 held when empty", int'(irqStatus[B_STALE]), 0);
    rxSend(nextVal());
    ticks(19); cyc();
    chkEq("R6 before 20 ticks", int'(irqStatus[B_STALE]), 0);
    ticks(1); cyc();
    chkEq("R6 at 20 ticks", int'(irqStatus[B_STALE]), 1);
    rxQ.push_back(8'h77);
    rxByteValid = 1'b1; rxByte = 8'h77; irqClear = 5'b00100;
    cyc();
    rxByteValid = 1'b0; irqClear = '0;
    cyc();
    chkEq("R6 restart on byte", int'(irqStatus[B_STALE]), 0);
    rxSend(nextVal()); rxSend(nextVal());
    ticks(25); cyc();
    chkEq("R6 none at high level", int'(irqStatus[B_STALE]), 0);
    while (rxQ.size() > 0) rxTake("R1 rx order stale");

    // R10 and R9
    clr(5'b11111);
    repeat (4) rxSend(nextVal());
    cyc();
    chkEq("R4 loaded level 4", int'(irqStatus[B_HIGH]), 1);
    irqEnable = 5'b00000; #1;
    chkEq("R10 none enabled", int'(irq), 0);
    irqEnable = 5'b00100; #1;
    chkEq("R10 other cause enabled", int'(irq), 0);
    irqEnable = 5'b00001; #1;
    chkEq("R10 cause enabled", int'(irq), 1);
    clr(5'b00001);
    chkEq("R9 cleared", int'(irqStatus[B_HIGH]), 0);
    chkEq("R10 irq after clear", int'(irq), 0);
    cyc();
    chkEq("R9 level returns", int'(irqStatus[B_HIGH]), 1);
    irqEnable = '0;

    // R11 zero write ignored
    rxTake("R1 rx order cfg");
    clr(5'b00001); cyc();
    chkEq("R4 below level 4", int'(irqStatus[B_HIGH]), 0);
    cfgSet(0, 3, 2); cyc(); cyc();
    chkEq("R11 zero ignored", int'(irqStatus[B_HIGH]), 0);
    cfgSet(3, 3, 2); cyc();
    chkEq("R11 load applied", int'(irqStatus[B_HIGH]), 1);
    while (rxQ.size() > 0) rxTake("R1 rx order cfg");

    // Transmit path with low level 3
    repeat (3) txSend(nextVal());
    clr(5'b00010); cyc();
    chkEq("R5 at 3", int'(irqStatus[B_LOW]), 0);
    chkEq("R12 valid", int'(txByteValid), 1);
    txTake("R12 tx head"); cyc();
    chkEq("R5 below 3", int'(irqStatus[B_LOW]), 1);
    txQ.push_back(8'h5D);
    chkEq("R12 head during pushpop", int'(txByte), int'(txQ[0]));
    hostTxPush = 1'b1; hostTxData = 8'h5D; txReady = 1'b1;
    cyc();
    hostTxPush = 1'b0; txReady = 1'b0;
    void'(txQ.pop_front());
    chkEq("R2 tx pushpop count", int'(txCount), 2);
    repeat (DEPTH - 2) txSend(nextVal());
    chkEq("R1 tx full", int'(txCount), DEPTH);
    chkEq("R8 no err yet", int'(irqStatus[B_ERR]), 0);
    hostTxPush = 1'b1; hostTxData = 8'hEE; txReady = 1'b1;
    cyc();
    hostTxPush = 1'b0; txReady = 1'b0;
    void'(txQ.pop_front());
    chkEq("R8 push ignored", int'(txCount), DEPTH - 1);
    chkEq("R8 err set", int'(irqStatus[B_ERR]), 1);
    while (txQ.size() > 0) txTake("R12 tx order full");
    chkEq("R12 empty valid", int'(txByteValid), 0);
    chkEq("R1 tx drained", int'(txCount), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule